// File: doc/BRIEF.md
# Slicer Code Decoder and Sync Pulse Classifier

This block sits behind an external bank of threshold comparators that slice a composite video signal. On every cycle where the sample strobe is high, it takes one byte from the comparator bank. The upper four bits form a thermometer code. The block turns that code into one of two things: a sync indication, or a two-bit brightness level. A code outside the legal set is flagged as an error. Each decoded sample appears one clock later as a registered valid/level/sync/error word.

The block also measures how long sync stays asserted, counted in samples. A pulse that lasts no more than a set number of samples is a horizontal sync, and its end is marked by a one-cycle pulse. A longer pulse is a vertical sync, and it is reported once by a one-cycle pulse as soon as its length passes the threshold.

A capture request arms a watchdog. If no vertical sync arrives within a set number of samples, the watchdog raises a sticky timeout flag. That flag tells the capture logic downstream that no frame was taken.

Top module: `slicer_sync_decoder`

## Requirements
- R1: A sample whose bits [7:4] are 1000 is decoded as sync: out_sync is 1 and out_level is 0.
- R2: Bits [7:4] of 0000, 0001, 0011 and 0111 decode to out_level 0, 1, 2 and 3, with out_sync and out_code_err both 0.
- R3: Bits [3:0] of slicer_in have no effect on any output.
- R4: Any other value of bits [7:4] sets out_code_err and gives out_level 0 with out_sync 0. Such a sample counts as non-sync.
- R5: A sample taken at a clock edge with sample_en high shows up on the outputs after that edge, with out_valid 1. After an edge with sample_en low, out_valid, out_level, out_sync and out_code_err are all 0. Cycles without sample_en neither extend nor break a sync run.
- R6: vsync_detected pulses for one cycle together with the (VSYNC_MIN+1)-th consecutive sync sample. It does not pulse again within the same run, however long the run lasts (the run counter saturates).
- R7: hsync_end pulses for one cycle together with the first non-sync sample after a run of 1 to VSYNC_MIN sync samples. It does not pulse after a vertical-length run.
- R8: After capture_start, if TIMEOUT_SAMPLES samples pass without a vertical sync, vsync_timeout rises. It stays at 1 until the next capture_start or reset.
- R9: A vertical sync inside the window disarms the watchdog, so no timeout follows. A new capture_start clears vsync_timeout and restarts the window from zero.
- R10: After reset, every output is 0, and no timeout occurs until capture_start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_en | input | 1 | Sample strobe; slicer_in is taken when high |
| slicer_in | input | 8 | Comparator snapshot; bits [7:4] carry the code, bits [3:0] are don't-care |
| capture_start | input | 1 | Arms the vertical-sync watchdog and clears any timeout |
| out_valid | output | 1 | Registered sample is present |
| out_level | output | 2 | Decoded brightness, 0 = black to 3 = white |
| out_sync | output | 1 | Sample is sync |
| out_code_err | output | 1 | Sample code was outside the legal set |
| hsync_end | output | 1 | One-cycle pulse: a horizontal sync pulse has just ended |
| vsync_detected | output | 1 | One-cycle pulse: the current sync run has reached vertical length |
| vsync_timeout | output | 1 | Sticky: the armed window expired without a vertical sync |

## Verification
The stimulus mixes random sync runs of many lengths with random brightness codes, illegal codes and random low nibbles, under a sample strobe that has gaps. A run of exactly VSYNC_MIN samples and a run of VSYNC_MIN+1 samples are compared to confirm where the horizontal/vertical split falls. A run far longer than VSYNC_MIN exposes any wrap or repeated report from the saturating counter. Directed windows show the difference between a vertical sync that arrives in time, a timeout on exactly the last sample of the window, and a restart through capture_start.

// File: rtl/vid_slicer_pkg.sv
package vid_slicer_pkg;

    typedef logic [1:0] level_t;

    typedef struct packed {
        logic   is_sync;
        logic   code_err;
        level_t level;
    } slice_dec_t;

    // Decode a full comparator byte; only the upper nibble matters.
    function automatic slice_dec_t decode_slice(input logic [7:0] raw);
        slice_dec_t d;
        d = '{is_sync: 1'b0, code_err: 1'b0, level: 2'd0};
        casez (raw)
            8'b1000_????: d.is_sync  = 1'b1;
            8'b0000_????: d.level    = 2'd0;
            8'b0001_????: d.level    = 2'd1;
            8'b0011_????: d.level    = 2'd2;
            8'b0111_????: d.level    = 2'd3;
            default:      d.code_err = 1'b1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/slice_code_decode.sv
module slice_code_decode
    import vid_slicer_pkg::*;
(
    input  logic [7:0]  raw_code,
    output slice_dec_t  dec
);
    always_comb dec = decode_slice(raw_code);
endmodule

// File: rtl/sync_run_classifier.sv
module sync_run_classifier #(
    parameter int VSYNC_MIN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic is_sync,
    output logic hs_evt,
    output logic vs_evt
);
    localparam int RUN_W = $clog2(VSYNC_MIN + 2);
    localparam logic [RUN_W-1:0] RUN_THR = RUN_W'(VSYNC_MIN);
    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(VSYNC_MIN + 1);

    logic [RUN_W-1:0] run_cnt;

    always_comb begin
        vs_evt = sample_en && is_sync && (run_cnt == RUN_THR);
        hs_evt = sample_en && !is_sync && (run_cnt != '0) && (run_cnt <= RUN_THR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
        end else if (sample_en) begin
            if (!is_sync)
                run_cnt <= '0;
            else if (run_cnt != RUN_SAT)
                run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/vsync_watchdog.sv
module vsync_watchdog #(
    parameter int TIMEOUT_SAMPLES = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic sample_en,
    input  logic capture_start,
    input  logic vs_evt,
    output logic timed_out
);
    localparam int WAIT_W = $clog2(TIMEOUT_SAMPLES + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(TIMEOUT_SAMPLES - 1);

    logic              armed;
    logic [WAIT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            wait_cnt  <= '0;
            timed_out <= 1'b0;
        end else if (capture_start) begin
            armed     <= 1'b1;
            wait_cnt  <= '0;
            timed_out <= 1'b0;
        end else if (armed && sample_en) begin
            if (vs_evt) begin
                armed <= 1'b0;
            end else if (wait_cnt == WAIT_LAST) begin
                armed     <= 1'b0;
                timed_out <= 1'b1;
            end else begin
                wait_cnt <= wait_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/slicer_sync_decoder.sv
module slicer_sync_decoder
    import vid_slicer_pkg::*;
#(
    parameter int VSYNC_MIN       = 40,
    parameter int TIMEOUT_SAMPLES = 20000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sample_en,
    input  logic [7:0] slicer_in,
    input  logic       capture_start,
    output logic       out_valid,
    output logic [1:0] out_level,
    output logic       out_sync,
    output logic       out_code_err,
    output logic       hsync_end,
    output logic       vsync_detected,
    output logic       vsync_timeout
);
    slice_dec_t dec;
    logic       hs_evt, vs_evt;

    slice_code_decode u_dec (
        .raw_code (slicer_in),
        .dec      (dec)
    );

    sync_run_classifier #(.VSYNC_MIN(VSYNC_MIN)) u_cls (
        .clk       (clk),
        .rst       (rst),
        .sample_en (sample_en),
        .is_sync   (dec.is_sync),
        .hs_evt    (hs_evt),
        .vs_evt    (vs_evt)
    );

    vsync_watchdog #(.TIMEOUT_SAMPLES(TIMEOUT_SAMPLES)) u_wd (
        .clk           (clk),
        .rst           (rst),
        .sample_en     (sample_en),
        .capture_start (capture_start),
        .vs_evt        (vs_evt),
        .timed_out     (vsync_timeout)
    );

    always_ff @(posedge clk) begin
        if (rst || !sample_en) begin
            out_valid      <= 1'b0;
            out_level      <= 2'd0;
            out_sync       <= 1'b0;
            out_code_err   <= 1'b0;
            hsync_end      <= 1'b0;
            vsync_detected <= 1'b0;
        end else begin
            out_valid      <= 1'b1;
            out_level      <= dec.level;
            out_sync       <= dec.is_sync;
            out_code_err   <= dec.code_err;
            hsync_end      <= hs_evt;
            vsync_detected <= vs_evt;
        end
    end
endmodule

// File: rtl/slicer_sync_decoder_chk.sv
module slicer_sync_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       capture_start,
    input logic       out_valid,
    input logic [1:0] out_level,
    input logic       out_sync,
    input logic       out_code_err,
    input logic       hsync_end,
    input logic       vsync_detected,
    input logic       vsync_timeout
);
    // R1
    sync_is_black_chk: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> (out_level == 2'd0));
    // R4
    err_not_sync_chk: assert property (@(posedge clk) disable iff (rst)
        out_code_err |-> (!out_sync && out_level == 2'd0));
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_sync || out_code_err || hsync_end || vsync_detected));
    // R6
    vsync_on_sync_chk: assert property (@(posedge clk) disable iff (rst)
        vsync_detected |-> out_sync);
    // R6
    vsync_single_chk: assert property (@(posedge clk) disable iff (rst)
        vsync_detected |=> !vsync_detected);
    // R7
    hsync_on_data_chk: assert property (@(posedge clk) disable iff (rst)
        hsync_end |-> (out_valid && !out_sync && !vsync_detected));
    // R8
    timeout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (vsync_timeout && !capture_start) |=> vsync_timeout);
    // R9
    start_clears_chk: assert property (@(posedge clk) disable iff (rst)
        capture_start |=> !vsync_timeout);
endmodule

bind slicer_sync_decoder slicer_sync_decoder_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .capture_start  (capture_start),
    .out_valid      (out_valid),
    .out_level      (out_level),
    .out_sync       (out_sync),
    .out_code_err   (out_code_err),
    .hsync_end      (hsync_end),
    .vsync_detected (vsync_detected),
    .vsync_timeout  (vsync_timeout)
);

// File: tb/tb_slicer_sync_decoder.sv
module tb_slicer_sync_decoder;
    localparam int VMIN = 6;
    localparam int TOUT = 50;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sample_en = 1'b0;
    logic [7:0] slicer_in = 8'h00;
    logic       capture_start = 1'b0;
    logic       out_valid, out_sync, out_code_err, hsync_end, vsync_detected, vsync_timeout;
    logic [1:0] out_level;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    int m_run = 0, m_wait = 0;
    bit m_armed = 0, m_to = 0;
    bit e_valid, e_sync, e_err, e_hs, e_vs;
    int e_level;

    always #4 clk = ~clk;

    slicer_sync_decoder #(.VSYNC_MIN(VMIN), .TIMEOUT_SAMPLES(TOUT)) dut (
        .clk(clk), .rst(rst), .sample_en(sample_en), .slicer_in(slicer_in),
        .capture_start(capture_start), .out_valid(out_valid), .out_level(out_level),
        .out_sync(out_sync), .out_code_err(out_code_err), .hsync_end(hsync_end),
        .vsync_detected(vsync_detected), .vsync_timeout(vsync_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int hi_code(input int lvl);
        case (lvl)
            0: return 0; 1: return 1; 2: return 3; 3: return 7;
            default: return 8;  // sync
        endcase
    endfunction

    // one clock: drive, predict, clock, compare
    task automatic step(input bit en, input logic [7:0] code, input bit start);
        bit s, er; int lv;
        sample_en = en; slicer_in = code; capture_start = start;
        s = 0; er = 0; lv = 0;
        case (code[7:4])
            4'b1000: s = 1;
            4'b0000: lv = 0;
            4'b0001: lv = 1;
            4'b0011: lv = 2;
            4'b0111: lv = 3;
            default: er = 1;
        endcase
        e_valid = en; e_sync = en && s; e_err = en && er; e_level = en ? lv : 0;
        e_hs = en && !s && m_run >= 1 && m_run <= VMIN;
        e_vs = en && s && m_run == VMIN;
        if (start) begin
            m_armed = 1; m_wait = 0; m_to = 0;
        end else if (m_armed && en) begin
            if (e_vs) m_armed = 0;
            else if (m_wait == TOUT - 1) begin m_to = 1; m_armed = 0; end
            else m_wait++;
        end
        if (en) m_run = s ? ((m_run < VMIN + 1) ? m_run + 1 : m_run) : 0;
        @(posedge clk); #2;
        chk("R5 out_valid", out_valid, e_valid);
        chk("R1 out_sync", out_sync, e_sync);
        chk("R2 out_level", out_level, e_level);
        chk("R4 out_code_err", out_code_err, e_err);
        chk("R7 hsync_end", hsync_end, e_hs);
        chk("R6 vsync_detected", vsync_detected, e_vs);
        chk("R8 vsync_timeout", vsync_timeout, m_to);
    endtask

    function automatic logic [7:0] byte_of(input int lvl);
        return {hi_code(lvl)[3:0], 4'($urandom_range(0, 15))};
    endfunction

    task automatic sync_run(input int n);
        for (int i = 0; i < n; i++) step(1'b1, byte_of(4), 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        chk("R10 valid at reset", out_valid, 0);
        chk("R10 timeout at reset", vsync_timeout, 0);
        chk("R10 hsync at reset", hsync_end, 0);
        @(negedge clk); rst = 1'b0;
        // R10: no timeout without arming
        for (int i = 0; i < TOUT + 5; i++) step(1'b1, byte_of(1), 1'b0);
        chk("R10 unarmed no timeout", vsync_timeout, 0);

        // R2 each level, R3 low nibble ignored
        for (int l = 0; l < 4; l++) begin
            step(1'b1, {hi_code(l)[3:0], 4'h0}, 1'b0);
            chk("R2 level direct", out_level, l);
            step(1'b1, {hi_code(l)[3:0], 4'hF}, 1'b0);
            chk("R3 low nibble ignored", out_level, l);
            chk("R3 no error from nibble", out_code_err, 0);
        end
        // R4 illegal code
        step(1'b1, 8'hA5, 1'b0);
        chk("R4 illegal flagged", out_code_err, 1);
        // R7 boundary: exactly VMIN sync samples is horizontal
        sync_run(VMIN);
        step(1'b1, byte_of(2), 1'b0);
        chk("R7 hsync at VMIN", hsync_end, 1);
        // R6 boundary: VMIN+1 is vertical; long run reports once, no hsync after
        sync_run(VMIN);
        step(1'b1, byte_of(4), 1'b0);
        chk("R6 vsync at VMIN+1", vsync_detected, 1);
        sync_run(3 * VMIN);
        step(1'b1, byte_of(0), 1'b0);
        chk("R7 no hsync after vertical", hsync_end, 0);
        // R5 gaps do not break a run
        sync_run(2);
        step(1'b0, 8'h00, 1'b0);
        chk("R5 gap clears valid", out_valid, 0);
        sync_run(VMIN - 1);
        chk("R5 run spans gap", vsync_detected, 1);
        step(1'b1, byte_of(1), 1'b0);

        // R8 timeout on exactly the last sample of the window
        step(1'b1, byte_of(1), 1'b1);
        for (int i = 0; i < TOUT - 1; i++) step(1'b1, byte_of(2), 1'b0);
        chk("R8 not yet timed out", vsync_timeout, 0);
        step(1'b1, byte_of(2), 1'b0);
        chk("R8 timeout raised", vsync_timeout, 1);
        step(1'b0, 8'h00, 1'b0);
        chk("R8 timeout sticky", vsync_timeout, 1);
        // R9 restart clears, vsync in window disarms
        step(1'b1, byte_of(1), 1'b1);
        chk("R9 start clears timeout", vsync_timeout, 0);
        sync_run(VMIN + 1);
        for (int i = 0; i < 2 * TOUT; i++) step(1'b1, byte_of(3), 1'b0);
        chk("R9 vsync prevents timeout", vsync_timeout, 0);

        // random mix
        for (int k = 0; k < 3000; k++) begin
            int pick = $urandom_range(0, 9);
            bit en = ($urandom_range(0, 3) != 0);
            bit st = ($urandom_range(0, 199) == 0);
            if (pick < 2) begin
                int n = $urandom_range(1, 2 * VMIN + 3);
                for (int j = 0; j < n; j++) step(($urandom_range(0, 5) != 0), byte_of(4), 1'b0);
            end else if (pick == 2) begin
                step(en, 8'($urandom_range(0, 255)), st);
            end else begin
                step(en, byte_of($urandom_range(0, 3)), st);
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule